// File: doc/BRIEF.md
# Dual Waveform Table Loader

This block keeps, for each output channel, a pair of waveform tables: one for the sine output and one for the cosine output. Each table has 1024 signed 16-bit entries. A position index per channel reads both tables of that channel in the same cycle, and the two samples come out one clock later. A downstream modulator or converter uses them.

The tables are refilled in bulk from a word stream with a valid/ready handshake, as a FIFO would deliver it. The host picks a channel, raises a request flag for the sine or the cosine table, and pushes 1024 words. The loader writes them into the chosen table in index order. It then raises a done indication that stays up until the host drops its request. Reads go on without interruption during a reload. A constant output gives the index of the last table entry, so software can size its transfers.

Top module: `dual_wave_table_loader`

## Requirements
- R1: `last_idx` always reads DEPTH-1, which is 1023 at the default size.
- R2: When the loader is idle and `wr_sin_req` or `wr_cos_req` is high at a clock edge, a transfer is armed at that edge for the channel on `ch_sel`. The first stream word accepted after that edge is written to index 0, the next to index 1, and so on. Tables of other channels are not touched.
- R3: A transfer takes exactly DEPTH valid words. Words that arrive after the last one do not change any table.
- R4: If both request flags are high when a transfer is armed, the sine table is loaded and the cosine table is left unchanged.
- R5: `load_done` rises in the cycle after the DEPTH-th word is accepted. It stays high while either request flag is high, and it falls in the cycle after both flags are low.
- R6: While `load_done` is high, a request flag that stays high does not arm a new transfer. A new transfer needs the flags to go low and then high again.
- R7: `sin_out` and `cos_out` of a channel show that channel's sine and cosine entries at `rd_idx`, one cycle after the index is presented. If an entry is written in the same cycle, the output shows its old value.
- R8: `s_ready` is always high. Words that arrive while no transfer is armed are consumed and discarded.
- R9: After reset, `load_done` is low and the loader is idle.
- R10: Cycles with `s_valid` low during a transfer neither write a table nor advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_sin_req | input | 1 | Request to reload the sine table |
| wr_cos_req | input | 1 | Request to reload the cosine table |
| ch_sel | input | CH_W | Target channel of the reload |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream ready (always high) |
| s_data | input | DW | Stream word, signed |
| rd_idx | input | NUM_CH*AW | Read index per channel, channel c at bits [c*AW +: AW] |
| sin_out | output | NUM_CH*DW | Sine sample per channel, channel c at bits [c*DW +: DW] |
| cos_out | output | NUM_CH*DW | Cosine sample per channel, channel c at bits [c*DW +: DW] |
| load_done | output | 1 | Transfer finished, held until the requests drop |
| last_idx | output | AW | Constant DEPTH-1 |

## Verification
The loader is exercised with several stream patterns:
- Back-to-back words show that the index advances once per accepted word.
- A stream with gaps tells a correct index hold apart from counting idle cycles.
- Extra words after the 1024th show where a transfer ends.
- Words sent with no request pending show whether the idle state really discards them.

Loads go to each channel and each table, and one load has both flags raised, so that crossed selection and priority errors show up in the untouched table. During every reload the bench moves the read indices and compares both outputs against a behavioural table model on every clock. This also covers the case of a read and a write to the same entry in one cycle.

// File: rtl/wtl_pkg.sv
package wtl_pkg;
   typedef enum logic [1:0] {LD_IDLE, LD_RUN, LD_DONE} ld_state_t;
   typedef enum logic {TBL_SIN = 1'b0, TBL_COS = 1'b1} tbl_sel_t;
endpackage

// File: rtl/wtl_ctrl.sv
module wtl_ctrl
   import wtl_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int CH_W  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_sin_req,
   input  logic                     wr_cos_req,
   input  logic [CH_W-1:0]          ch_sel,
   input  logic                     s_valid,
   output logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_addr,
   output logic [CH_W-1:0]          wr_ch,
   output tbl_sel_t                 wr_tbl,
   output logic                     busy,
   output logic                     done
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   ld_state_t       state_q;
   logic [AW-1:0]   cnt_q;
   logic [CH_W-1:0] ch_q;
   tbl_sel_t        tbl_q;
   logic            any_req;

   assign any_req = wr_sin_req | wr_cos_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         cnt_q   <= '0;
         ch_q    <= '0;
         tbl_q   <= TBL_SIN;
      end else begin
         case (state_q)
            LD_IDLE: if (any_req) begin
               state_q <= LD_RUN;
               cnt_q   <= '0;
               ch_q    <= ch_sel;
               tbl_q   <= wr_sin_req ? TBL_SIN : TBL_COS;
            end
            LD_RUN: if (s_valid) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) state_q <= LD_DONE;
            end
            LD_DONE: if (!any_req) state_q <= LD_IDLE;
            default: state_q <= LD_IDLE;
         endcase
      end
   end

   assign busy    = (state_q == LD_RUN);
   assign done    = (state_q == LD_DONE);
   assign wr_en   = busy & s_valid;
   assign wr_addr = cnt_q;
   assign wr_ch   = ch_q;
   assign wr_tbl  = tbl_q;
endmodule

// File: rtl/wtl_table.sv
module wtl_table #(
   parameter int DEPTH = 1024,
   parameter int DW    = 16
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DW-1:0]            rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/dual_wave_table_loader.sv
module dual_wave_table_loader
   import wtl_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DEPTH  = 1024,
   parameter int DW     = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_sin_req,
   input  logic                 wr_cos_req,
   input  logic [CH_W-1:0]      ch_sel,
   input  logic                 s_valid,
   output logic                 s_ready,
   input  logic [DW-1:0]        s_data,
   input  logic [NUM_CH*AW-1:0] rd_idx,
   output logic [NUM_CH*DW-1:0] sin_out,
   output logic [NUM_CH*DW-1:0] cos_out,
   output logic                 load_done,
   output logic [AW-1:0]        last_idx
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end

   logic            ctl_wr_en;
   logic [AW-1:0]   ctl_addr;
   logic [CH_W-1:0] ctl_ch;
   tbl_sel_t        ctl_tbl;
   logic            ctl_busy;

   wtl_ctrl #(.DEPTH(DEPTH), .CH_W(CH_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sin_req (wr_sin_req),
      .wr_cos_req (wr_cos_req),
      .ch_sel     (ch_sel),
      .s_valid    (s_valid),
      .wr_en      (ctl_wr_en),
      .wr_addr    (ctl_addr),
      .wr_ch      (ctl_ch),
      .wr_tbl     (ctl_tbl),
      .busy       (ctl_busy),
      .done       (load_done)
   );

   assign s_ready  = 1'b1;
   assign last_idx = AW'(DEPTH - 1);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      for (genvar t = 0; t < 2; t++) begin : g_tbl
         logic          we;
         logic [DW-1:0] rd;
         assign we = ctl_wr_en && (ctl_ch == CH_W'(c)) && (ctl_tbl == tbl_sel_t'(t));
         wtl_table #(.DEPTH(DEPTH), .DW(DW)) u_tbl (
            .clk   (clk),
            .we    (we),
            .waddr (ctl_addr),
            .wdata (s_data),
            .raddr (rd_idx[c*AW +: AW]),
            .rdata (rd)
         );
         if (t == 0) begin : g_sin
            assign sin_out[c*DW +: DW] = rd;
         end else begin : g_cos
            assign cos_out[c*DW +: DW] = rd;
         end
      end
   end
endmodule

// File: rtl/wtl_chk.sv
module wtl_chk #(
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_sin_req,
   input logic          wr_cos_req,
   input logic          s_valid,
   input logic          load_done,
   input logic          busy,
   input logic [AW-1:0] cnt,
   input logic          tbl
);
   localparam logic [AW-1:0] LAST = '1;

   // R2
   start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load_done && (wr_sin_req || wr_cos_req)) |=> (busy && cnt == '0));
   // R4
   sin_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load_done && wr_sin_req && wr_cos_req) |=> (tbl == 1'b0));
   // R3
   last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && s_valid && cnt == LAST) |=> (load_done && !busy));
   // R10
   gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !s_valid) |=> (busy && $stable(cnt)));
   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && (wr_sin_req || wr_cos_req)) |=> load_done);
   // R5
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && !wr_sin_req && !wr_cos_req) |=> (!load_done && !busy));
   // R6
   no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> !busy);
endmodule

bind dual_wave_table_loader wtl_chk #(.AW(AW)) u_wtl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_sin_req (wr_sin_req),
   .wr_cos_req (wr_cos_req),
   .s_valid    (s_valid),
   .load_done  (load_done),
   .busy       (ctl_busy),
   .cnt        (ctl_addr),
   .tbl        (ctl_tbl)
);

// File: tb/test_dual_wave_table_loader.sv
module test_dual_wave_table_loader;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2;
   localparam int DEP = 1024;
   localparam int DW  = 16;
   localparam int AW  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_sin_req = 1'b0, wr_cos_req = 1'b0;
   logic [0:0] ch_sel = '0;
   logic s_valid = 1'b0;
   logic s_ready;
   logic [DW-1:0] s_data = '0;
   logic [AW-1:0] ridx [NCH];
   logic [NCH*AW-1:0] rd_idx;
   logic [NCH*DW-1:0] sin_out, cos_out;
   logic load_done;
   logic [AW-1:0] last_idx;

   assign rd_idx = {ridx[1], ridx[0]};

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_wave_table_loader #(.NUM_CH(NCH), .DEPTH(DEP), .DW(DW)) i_dual_wave_table_loader (
      .clk(clk), .rst_n(rst_n), .wr_sin_req(wr_sin_req), .wr_cos_req(wr_cos_req),
      .ch_sel(ch_sel), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .rd_idx(rd_idx), .sin_out(sin_out), .cos_out(cos_out),
      .load_done(load_done), .last_idx(last_idx)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(int seed, int i);
      int v;
      v = seed * 7919 + i * 40503 + (i << 7);
      return v[15:0];
   endfunction

   // behavioural reference: tables, transfer progress, expected outputs
   logic [15:0] m_mem   [NCH][2][DEP];
   bit          m_known [NCH][2][DEP];
   int m_state = 0;
   int m_cnt = 0;
   int m_ch = 0;
   int m_tbl = 0;
   logic [15:0] e_out [NCH][2];
   bit          e_known [NCH][2];
   bit          e_done = 0;

   initial begin
      ridx[0] = '0;
      ridx[1] = '0;
      for (int c = 0; c < NCH; c++)
         for (int t = 0; t < 2; t++) begin
            e_known[c][t] = 0;
            for (int i = 0; i < DEP; i++) m_known[c][t][i] = 0;
         end
   end

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++)
         for (int t = 0; t < 2; t++) begin
            e_known[c][t] = m_known[c][t][ridx[c]];
            e_out[c][t]   = m_mem[c][t][ridx[c]];
         end
      if (!rst_n) begin
         m_state = 0;
      end else begin
         case (m_state)
            0: if (wr_sin_req || wr_cos_req) begin
               m_state = 1;
               m_cnt = 0;
               m_ch = int'(ch_sel);
               m_tbl = wr_sin_req ? 0 : 1;
            end
            1: if (s_valid) begin
               m_mem[m_ch][m_tbl][m_cnt] = s_data;
               m_known[m_ch][m_tbl][m_cnt] = 1;
               m_cnt++;
               if (m_cnt == DEP) m_state = 2;
            end
            default: if (!wr_sin_req && !wr_cos_req) m_state = 0;
         endcase
      end
      e_done = (m_state == 2);
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5", 32'(load_done), 32'(e_done), "load_done per cycle");
         chk("R8", 32'(s_ready), 32'd1, "s_ready");
         chk("R1", 32'(last_idx), 32'd1023, "last_idx");
         for (int c = 0; c < NCH; c++) begin
            if (e_known[c][0]) chk("R7", 32'(sin_out[c*DW +: DW]), 32'(e_out[c][0]), "sin_out vs model");
            if (e_known[c][1]) chk("R7", 32'(cos_out[c*DW +: DW]), 32'(e_out[c][1]), "cos_out vs model");
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1;
         bad++;
         $display("FAIL watchdog expired act=%0d exp=below 100000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic stream(int seed, int n, bit gaps);
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 5 == 3)) begin
            @(negedge clk);
            s_valid = 1'b0;
            s_data = 16'hDEAD;
            ridx[0] = AW'(i * 3);
            @(posedge clk);
         end
         @(negedge clk);
         s_valid = 1'b1;
         s_data = pat(seed, i);
         ridx[0] = AW'(i);
         ridx[1] = AW'(i + 1);
         @(posedge clk);
      end
      @(negedge clk);
      s_valid = 1'b0;
   endtask

   task automatic arm(bit s, bit c, int ch);
      @(negedge clk);
      wr_sin_req = s;
      wr_cos_req = c;
      ch_sel = 1'(ch);
      @(posedge clk);
   endtask

   task automatic release_flags();
      @(negedge clk);
      wr_sin_req = 1'b0;
      wr_cos_req = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R5", 32'(load_done), 32'd0, "done clears after flags drop");
   endtask

   task automatic load(bit s, bit c, int ch, int seed, bit gaps);
      arm(s, c, ch);
      stream(seed, DEP, gaps);
      @(posedge clk);
      @(negedge clk);
      chk("R5", 32'(load_done), 32'd1, "done after last word");
      release_flags();
   endtask

   task automatic rd(string tag, int ch, int t, int idx, logic [15:0] exp);
      @(negedge clk);
      ridx[ch] = AW'(idx);
      @(posedge clk);
      @(negedge clk);
      if (t == 0) chk(tag, 32'(sin_out[ch*DW +: DW]), 32'(exp), "sine readback");
      else        chk(tag, 32'(cos_out[ch*DW +: DW]), 32'(exp), "cosine readback");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", 32'(load_done), 32'd0, "done in reset");
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R9", 32'(load_done), 32'd0, "done after reset");
      chk("R1", 32'(last_idx), 32'd1023, "last index");

      load(1, 0, 0, 1, 0);
      load(0, 1, 0, 2, 1);
      load(1, 0, 1, 3, 0);
      load(0, 1, 1, 4, 0);
      rd("R2", 0, 0, 0, pat(1, 0));
      rd("R2", 0, 0, 1, pat(1, 1));
      rd("R3", 0, 0, 1023, pat(1, 1023));
      rd("R2", 1, 1, 512, pat(4, 512));
      rd("R2", 1, 0, 77, pat(3, 77));
      rd("R10", 0, 1, 7, pat(2, 7));
      rd("R10", 0, 1, 1023, pat(2, 1023));

      // both flags: sine wins
      load(1, 1, 0, 5, 0);
      rd("R4", 0, 0, 9, pat(5, 9));
      rd("R4", 0, 1, 9, pat(2, 9));

      // flags held past done, extra words must be ignored, no re-arm
      arm(1, 0, 1);
      stream(6, DEP, 0);
      stream(7, 1100, 0);
      @(negedge clk);
      chk("R6", 32'(load_done), 32'd1, "done held, no re-arm");
      rd("R3", 1, 0, 0, pat(6, 0));
      rd("R6", 1, 0, 500, pat(6, 500));
      release_flags();

      // idle words discarded
      stream(8, 50, 0);
      @(negedge clk);
      chk("R8", 32'(load_done), 32'd0, "idle words start nothing");
      rd("R8", 0, 0, 0, pat(5, 0));
      rd("R8", 1, 1, 3, pat(4, 3));

      // reload while reading the same entries (old value on collision)
      load(0, 1, 0, 9, 0);
      rd("R7", 0, 1, 100, pat(9, 100));

      repeat (3) @(posedge clk);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule